// File: doc/BRIEF.md
# Configurable-Width IQ Sample Packer

This block sits between the receive channels and the receive FIFO. On a sample strobe it captures one 16-bit I value and one 16-bit Q value for every active channel. It cuts each value down to a run-time selected width of 16, 8, 4, 2 or 1 bits, keeping the most significant bits. It then packs the results into 16-bit words for the FIFO.

Components are placed one per cycle after the strobe, in a fixed order: channel 0 I, channel 0 Q, channel 1 I, and so on. A word is handed to the FIFO as soon as its last slot is filled. At narrow widths, one word can collect samples from several strobes. A reverse mode flips the slot placement inside each word, so that a recorder writing whole words sees samples in arrival order from the top bits down.

The FIFO port writes with a one-cycle valid. A word that completes while the FIFO is not ready is discarded, and an overrun pulse flags the loss.

Top module: `iq_sample_packer`

## Requirements
- R1: `widthSel` codes 0, 1, 2, 3 and 4 select 16, 8, 4, 2 and 1 bits per component. A word holds S = 16 / width slots.
- R2: An N-bit sample is bits [15:16-N] of the captured 16-bit component.
- R3: With `reverseOrder` low, slot k occupies bits [k*N +: N]. Slot 0 receives the first component taken. Components are taken in the order I0, Q0, I1, Q1, and so on.
- R4: A word is written exactly when slot S-1 is filled. Components from later strobes continue filling an unfinished word.
- R5: With `reverseOrder` high, slot k occupies bits [(S-1-k)*N +: N].
- R6: `chanCount` holds the number of active channels minus one. Only channels 0 to `chanCount` are packed, and inputs of the other channels have no effect on the output.
- R7: `wordValid` pulses for one cycle with the word, and only when `fifoReady` was high in the completing cycle. Otherwise the word is dropped, and `overrun` pulses for one cycle instead.
- R8: A change of the effective width discards any partly filled word, and the next component goes to slot 0.
- R9: While `rst_n` is low, `wordData`, `wordValid` and `overrun` are zero. After reset, any earlier partial word is gone.
- R10: Unpacking one strobe takes 2*(`chanCount`+1) cycles. A strobe that arrives during that time is ignored.
- R11: `widthSel` codes 5 to 7 behave as code 4 (1 bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleStrobe | input | 1 | Capture one sample set from all channels |
| iData | input | 64 | I components, channel c in bits [16c +: 16] |
| qData | input | 64 | Q components, channel c in bits [16c +: 16] |
| widthSel | input | 3 | Quantization width code |
| chanCount | input | 2 | Active channels minus one |
| reverseOrder | input | 1 | Reverse slot placement within a word |
| fifoReady | input | 1 | Receive FIFO can accept a word |
| wordData | output | 16 | Packed word |
| wordValid | output | 1 | FIFO write enable |
| overrun | output | 1 | Completed word dropped (FIFO not ready) |

## Verification
The bench walks a table of width, channel-count and order settings through a reference packer, covering several cases:
- Words spanning several strobes. A design that restarted a word on each strobe would emit too many words with zero upper slots.
- Reverse placement at 1, 2 and 4 bits. A mirrored slot formula would put samples in swapped positions.
- An undefined width code. A design that did not treat codes 5 to 7 as 1 bit would produce the wrong word count.
- Inactive channels carrying data. Packing them would shift every later slot.

Directed cases cover the following:
- A width switch and a reset in the middle of a word. Stale bits left behind would corrupt the next word.
- A back-to-back strobe. If it were accepted, it would restart the sequencer and repeat words.
- A stalled FIFO. If the word were not dropped, it would be written anyway or the overrun pulse would be lost.

// File: rtl/iq_pack_pkg.sv
package iq_pack_pkg;
  parameter int unsigned WORD_W   = 16;
  parameter int unsigned SAMPLE_W = 16;
  parameter int unsigned NUM_CH   = 4;
  parameter int unsigned CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  parameter int unsigned COMP_W   = CH_W + 1;
  parameter int unsigned SLOT_W   = $clog2(WORD_W);
  parameter int unsigned MAX_LOG  = $clog2(WORD_W);
  parameter int unsigned LOG_W    = $clog2(MAX_LOG + 1);

  // Strobes and indices handed from the sequencer to the datapath.
  typedef struct packed {
    logic              capture;
    logic              insert;
    logic              emit;
    logic              clear;
    logic [COMP_W-1:0] compSel;
    logic [SLOT_W-1:0] slotSel;
    logic [LOG_W-1:0]  widthLog;
  } pack_ctrl_t;
endpackage

// File: rtl/iq_pack_ctrl.sv
module iq_pack_ctrl
  import iq_pack_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sampleStrobe,
  input  logic [LOG_W-1:0] widthSel,
  input  logic [CH_W-1:0]  chanCount,
  output pack_ctrl_t       ctrl
);
  logic [LOG_W-1:0]  widthLog, widthLogPrev;
  logic [SLOT_W-1:0] slotIdx, lastSlot;
  logic [COMP_W-1:0] compIdx, lastComp;
  logic              busy, widthChanged;

  // Codes beyond the 1-bit code saturate to 1 bit.
  always_comb begin
    if (widthSel >= LOG_W'(MAX_LOG)) widthLog = '0;
    else                             widthLog = LOG_W'(MAX_LOG - widthSel);
  end

  assign lastSlot     = SLOT_W'((WORD_W >> widthLog) - 1);
  assign lastComp     = {chanCount, 1'b1};
  assign widthChanged = (widthLog != widthLogPrev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      compIdx      <= '0;
      slotIdx      <= '0;
      widthLogPrev <= LOG_W'(MAX_LOG);
    end else begin
      widthLogPrev <= widthLog;
      if (widthChanged) begin
        busy    <= 1'b0;
        slotIdx <= '0;
      end else begin
        if (busy) begin
          slotIdx <= (slotIdx == lastSlot) ? '0 : slotIdx + 1'b1;
          if (compIdx == lastComp) busy <= 1'b0;
          else                     compIdx <= compIdx + 1'b1;
        end
        if (sampleStrobe && !busy) begin
          busy    <= 1'b1;
          compIdx <= '0;
        end
      end
    end
  end

  always_comb begin
    ctrl.capture  = sampleStrobe && !busy && !widthChanged;
    ctrl.insert   = busy && !widthChanged;
    ctrl.emit     = busy && !widthChanged && (slotIdx == lastSlot);
    ctrl.clear    = widthChanged;
    ctrl.compSel  = compIdx;
    ctrl.slotSel  = slotIdx;
    ctrl.widthLog = widthLog;
  end

  // R8: a width switch leaves the sequencer idle at slot 0
  p_clear_on_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    widthChanged |=> (slotIdx == '0) && !busy);

  // R10: a strobe during unpacking does not restart the component walk
  p_ignore_busy_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sampleStrobe && !widthChanged && compIdx != lastComp)
      |=> busy && (compIdx == COMP_W'($past(compIdx) + 1'b1)));
endmodule

// File: rtl/iq_pack_dp.sv
module iq_pack_dp
  import iq_pack_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  pack_ctrl_t                 ctrl,
  input  logic [NUM_CH*SAMPLE_W-1:0] iData,
  input  logic [NUM_CH*SAMPLE_W-1:0] qData,
  input  logic                       reverseOrder,
  input  logic                       fifoReady,
  output logic [WORD_W-1:0]          wordData,
  output logic                       wordValid,
  output logic                       overrun
);
  localparam int unsigned SHIFT_W = $clog2(SAMPLE_W + 1);

  logic [NUM_CH*SAMPLE_W-1:0] capI, capQ;
  logic [WORD_W-1:0]          acc, placed, merged;
  logic [SAMPLE_W-1:0]        comp, compTrunc;
  logic [CH_W-1:0]            chIdx;
  logic [SLOT_W-1:0]          slotEff, slotTop;
  logic [SHIFT_W-1:0]         shAmt;

  assign chIdx = ctrl.compSel[COMP_W-1:1];

  always_comb begin
    comp      = ctrl.compSel[0] ? capQ[int'(chIdx)*SAMPLE_W +: SAMPLE_W]
                                : capI[int'(chIdx)*SAMPLE_W +: SAMPLE_W];
    shAmt     = SHIFT_W'(SAMPLE_W - (1 << ctrl.widthLog));
    compTrunc = comp >> shAmt;
    slotTop   = SLOT_W'((WORD_W >> ctrl.widthLog) - 1);
    slotEff   = reverseOrder ? (slotTop - ctrl.slotSel) : ctrl.slotSel;
    placed    = WORD_W'(compTrunc << (int'(slotEff) << ctrl.widthLog));
    merged    = acc | placed;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capI      <= '0;
      capQ      <= '0;
      acc       <= '0;
      wordData  <= '0;
      wordValid <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      wordValid <= ctrl.emit && fifoReady;
      overrun   <= ctrl.emit && !fifoReady;
      if (ctrl.capture) begin
        capI <= iData;
        capQ <= qData;
      end
      if (ctrl.clear)       acc <= '0;
      else if (ctrl.insert) acc <= ctrl.emit ? '0 : merged;
      if (ctrl.emit && fifoReady) wordData <= merged;
    end
  end

  // R7: a write only follows a ready FIFO
  p_valid_needs_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wordValid |-> $past(fifoReady));

  // R7: a dropped word never also shows as written
  p_overrun_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !wordValid && !$past(fifoReady));

  // R4: a fresh word starts from an empty accumulator
  p_empty_at_slot0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.slotSel == '0) |-> (acc == '0));
endmodule

// File: rtl/iq_sample_packer.sv
module iq_sample_packer
  import iq_pack_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sampleStrobe,
  input  logic [NUM_CH*SAMPLE_W-1:0] iData,
  input  logic [NUM_CH*SAMPLE_W-1:0] qData,
  input  logic [LOG_W-1:0]           widthSel,
  input  logic [CH_W-1:0]            chanCount,
  input  logic                       reverseOrder,
  input  logic                       fifoReady,
  output logic [WORD_W-1:0]          wordData,
  output logic                       wordValid,
  output logic                       overrun
);
  pack_ctrl_t ctrl;

  iq_pack_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .sampleStrobe (sampleStrobe),
    .widthSel     (widthSel),
    .chanCount    (chanCount),
    .ctrl         (ctrl)
  );

  iq_pack_dp u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl         (ctrl),
    .iData        (iData),
    .qData        (qData),
    .reverseOrder (reverseOrder),
    .fifoReady    (fifoReady),
    .wordData     (wordData),
    .wordValid    (wordValid),
    .overrun      (overrun)
  );
endmodule

// File: tb/iq_sample_packer_bench.sv
module iq_sample_packer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sampleStrobe = 1'b0;
  logic [63:0] iData = '0, qData = '0;
  logic [2:0]  widthSel = 3'd0;
  logic [1:0]  chanCount = 2'd0;
  logic        reverseOrder = 1'b0;
  logic        fifoReady = 1'b1;
  logic [15:0] wordData;
  logic        wordValid, overrun;

  always #5 clk = ~clk;

  iq_sample_packer u_iq_sample_packer (
    .clk(clk), .rst_n(rst_n), .sampleStrobe(sampleStrobe), .iData(iData),
    .qData(qData), .widthSel(widthSel), .chanCount(chanCount),
    .reverseOrder(reverseOrder), .fifoReady(fifoReady),
    .wordData(wordData), .wordValid(wordValid), .overrun(overrun));

  int checks = 0, errors = 0;
  int gotCount = 0, ovCount = 0, expCount = 0, stimIdx = 0;
  logic [15:0] gotWords [0:127];
  logic [15:0] expWords [0:127];
  logic [15:0] mAcc;
  int mSlot;

  typedef struct packed {
    logic [2:0] sel;
    logic       rev;
    logic [1:0] ch;
    logic [7:0] strobes;
  } row_t;

  // R1 R3 R4 (forward), R5 (reverse), R6 (channel subsets), R11 (code 7)
  localparam row_t ROWS [0:8] = '{
    '{3'd0, 1'b0, 2'd3, 8'd2},
    '{3'd1, 1'b0, 2'd1, 8'd2},
    '{3'd2, 1'b0, 2'd3, 8'd3},
    '{3'd2, 1'b1, 2'd1, 8'd4},
    '{3'd3, 1'b0, 2'd0, 8'd8},
    '{3'd4, 1'b0, 2'd0, 8'd16},
    '{3'd4, 1'b1, 2'd2, 8'd8},
    '{3'd7, 1'b0, 2'd0, 8'd8},
    '{3'd3, 1'b1, 2'd3, 8'd4}
  };

  always @(negedge clk) begin
    if (wordValid) begin
      gotWords[gotCount] = wordData;
      gotCount++;
    end
    if (overrun) ovCount++;
  end

  function automatic logic [15:0] iVal(int s, int c);
    return 16'(s * 32'h3B1D + c * 32'h1C07 + 32'h9A55);
  endfunction
  function automatic logic [15:0] qVal(int s, int c);
    return 16'((s * 32'h52E3) ^ (c * 32'h0F31) ^ 32'h6C99);
  endfunction
  function automatic int widthOf(logic [2:0] sel);
    return (sel >= 3'd4) ? 1 : (16 >> sel);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic modelClear();
    mAcc = '0; mSlot = 0; expCount = 0;
  endtask

  // Reference packing of one component from the requirement text.
  task automatic modelPush(input logic [15:0] v);
    int w, slots, k;
    w = widthOf(widthSel);
    slots = 16 / w;
    k = reverseOrder ? (slots - 1 - mSlot) : mSlot;
    for (int b = 0; b < w; b++) mAcc[k * w + b] = v[16 - w + b];
    mSlot++;
    if (mSlot == slots) begin
      if (fifoReady) begin
        expWords[expCount] = mAcc;
        expCount++;
      end
      mAcc = '0; mSlot = 0;
    end
  endtask

  task automatic strobe(input int gap, input bit model);
    for (int c = 0; c < 4; c++) begin
      iData[c*16 +: 16] = iVal(stimIdx, c);
      qData[c*16 +: 16] = qVal(stimIdx, c);
    end
    sampleStrobe = 1'b1;
    if (model)
      for (int c = 0; c <= int'(chanCount); c++) begin
        modelPush(iVal(stimIdx, c));
        modelPush(qVal(stimIdx, c));
      end
    stimIdx++;
    @(negedge clk);
    sampleStrobe = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    gotCount = 0; ovCount = 0;
    modelClear();
  endtask

  task automatic compareWords(input string req);
    check(gotCount == expCount, req, gotCount, expCount);
    for (int k = 0; k < expCount && k < gotCount; k++)
      check(gotWords[k] == expWords[k], req, gotWords[k], expWords[k]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9: outputs idle during reset
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check({wordData, wordValid, overrun} == '0, "R9 reset outputs",
          {14'b0, wordData, wordValid, overrun}, 0);
    doReset();

    // Table walk
    for (int r = 0; r < 9; r++) begin
      widthSel = ROWS[r].sel; reverseOrder = ROWS[r].rev;
      chanCount = ROWS[r].ch;
      doReset();
      for (int s = 0; s < int'(ROWS[r].strobes); s++) strobe(11, 1'b1);
      repeat (4) @(negedge clk);
      compareWords($sformatf("R1 R2 R3 R4 R5 R6 R11 table row %0d", r));
    end

    // R10: back-to-back strobe is ignored
    widthSel = 3'd0; reverseOrder = 1'b0; chanCount = 2'd3;
    doReset();
    for (int c = 0; c < 4; c++) begin
      iData[c*16 +: 16] = iVal(stimIdx, c);
      qData[c*16 +: 16] = qVal(stimIdx, c);
      modelPush(iVal(stimIdx, c));
      modelPush(qVal(stimIdx, c));
    end
    sampleStrobe = 1'b1;
    @(negedge clk);
    stimIdx++;
    iData = ~iData; qData = ~qData;
    @(negedge clk);
    sampleStrobe = 1'b0;
    repeat (14) @(negedge clk);
    compareWords("R10 strobe while busy");

    // R7: FIFO not ready drops words and pulses overrun
    widthSel = 3'd0; chanCount = 2'd0;
    doReset();
    fifoReady = 1'b0;
    strobe(6, 1'b1);
    check(gotCount == 0, "R7 no write when not ready", gotCount, 0);
    check(ovCount == 2, "R7 overrun pulses", ovCount, 2);
    fifoReady = 1'b1;
    gotCount = 0; modelClear();
    strobe(6, 1'b1);
    compareWords("R7 writes after ready returns");

    // R8: width switch discards a partial word
    widthSel = 3'd4; chanCount = 2'd0;
    doReset();
    repeat (3) strobe(5, 1'b0);
    widthSel = 3'd1;
    repeat (2) @(negedge clk);
    modelClear();
    strobe(6, 1'b1);
    compareWords("R8 partial cleared on width change");

    // R9: reset discards a partial word
    widthSel = 3'd4; chanCount = 2'd0;
    doReset();
    repeat (3) strobe(5, 1'b0);
    doReset();
    for (int s = 0; s < 8; s++) strobe(5, 1'b1);
    repeat (3) @(negedge clk);
    compareWords("R9 partial cleared by reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule